// File: doc/BRIEF.md
# Register-Level Serial Port Controller

This block is a synchronous serial slave that gives a host access to a small bank of control registers. Each register holds one to four bytes. Every operation opens with an instruction byte that carries the direction and a register address. The controller then moves every byte of that register, most significant bit first. It works out the byte sequence from the register address, so the host never gives byte addresses. Several operations may follow one another while chip select stays low.

Writes are double-buffered. Serial data first fills a staging word. When the word is complete it goes into a holding buffer for that register. An update strobe copies all holding buffers into the active registers together, one clock after the strobe's rising edge is registered. The active registers drive the parallel view the rest of the chip uses. Reads return the active contents.

An abort input, or chip select going high, drops the current operation at any bit. A partial write then touches no buffer, and the next serial byte is taken as a new instruction. The serial clock, chip select and data lines are sampled by the system clock, which must run well above the serial clock rate.

Top module: `spc_top`

## Requirements
- R1: After reset every active register reads as zero on the parallel view and `sdo` is 0.
- R2: The instruction byte is shifted MSB first. Bit 7 is 1 for a read and 0 for a write. Bits 4:0 are the register address. Bits 6:5 have no effect.
- R3: An address `a` selects a register of `(a mod 4) + 1` bytes. Exactly that many data bytes follow the instruction, MSB first. The controller then expects a new instruction byte within the same chip-select window.
- R4: A completed write changes only the holding buffer. The active register and the parallel view keep their values until an update.
- R5: A rising edge of `io_update` copies every holding buffer into its active register. The copy happens on the second clock edge at which `io_update` is sampled high: the first edge registers the strobe and the second performs the copy.
- R6: A read shifts out the active register value, MSB first. The first data bit is valid on `sdo` after the last instruction bit's rising `sck` edge. Each later bit follows a falling `sck` edge, so the host samples `sdo` just before each rising `sck` edge.
- R7: `io_abort` high drops the current operation at any bit. A partly written register leaves both its buffer and its active value unchanged. `sdo` goes to 0, and the next byte is decoded as an instruction.
- R8: `csn` high ends any operation in the same way as an abort.
- R9: Addresses at or above `NUM_REGS` are accepted with the same byte count. Writes to them change no register, and reads of them return zeros.
- R10: If a write finishes on the same clock edge as an update copy, the copy uses the buffer contents from before that write. The new value stays pending until the next update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host, idles low |
| csn | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in, sampled on rising `sck` |
| sdo | output | 1 | Serial read data, changes after falling `sck` |
| io_abort | input | 1 | Drops the current serial operation |
| io_update | input | 1 | Strobe; its rising edge commits buffers to active registers |
| act_regs | output | NUM_REGS*32 | Active registers; register i at bits [32*i+31:32*i], value right-aligned |

## Verification
Two events can fall in the same clock edge: a serial write completing into its holding buffer, and the commit that copies buffers to the active registers. The bench raises `io_update` exactly one clock before the final rising `sck` edge of a write, so the registered commit lands on that edge. It then expects the parallel view to show the old value, and the new value only after a second strobe. Abort and chip-select release are also applied in the middle of writes and reads. The bench then checks that no buffer was touched and that the next byte is decoded as a fresh instruction.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int INSTR_BITS = 8;
  localparam int ADDR_W     = 5;
  localparam int MAX_BYTES  = 4;
  localparam int WORD_W     = MAX_BYTES * 8;
  localparam int CNT_W      = $clog2(WORD_W) + 1;

  typedef enum logic {PH_INSTR = 1'b0, PH_DATA = 1'b1} phase_t;

  // byte length of a register as a function of its address
  function automatic int reg_bytes(input logic [ADDR_W-1:0] a);
    return (int'(a) % MAX_BYTES) + 1;
  endfunction

  function automatic logic [CNT_W-1:0] reg_bits(input logic [ADDR_W-1:0] a);
    return CNT_W'(reg_bytes(a) * 8);
  endfunction

  // place a right-aligned register value at the top of the shift word
  function automatic logic [WORD_W-1:0] msb_align(input logic [WORD_W-1:0] w,
                                                  input logic [ADDR_W-1:0] a);
    return w << (WORD_W - reg_bytes(a) * 8);
  endfunction
endpackage

// File: rtl/spc_shifter.sv
module spc_shifter
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              sdi,
  input  logic              abort,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] dec_addr,
  output logic              instr_done,
  output logic              wr_done,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              sdo,
  output phase_t            phase,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic              sck_q;
  logic [WORD_W-1:0] rx_q, tx_q, rx_next;
  phase_t            ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sck_rise, sck_fall, live, data_last;

  assign sck_rise  = sck & ~sck_q;
  assign sck_fall  = ~sck & sck_q;
  assign live      = ~csn & ~abort;
  assign rx_next   = {rx_q[WORD_W-2:0], sdi};
  assign dec_addr  = rx_next[ADDR_W-1:0];

  assign instr_done = live & sck_rise & (ph_q == PH_INSTR)
                    & (cnt_q == CNT_W'(INSTR_BITS - 1));
  assign data_last  = live & sck_rise & (ph_q == PH_DATA)
                    & (cnt_q == reg_bits(addr_q) - CNT_W'(1));

  assign wr_done = data_last & ~rd_q;
  assign wr_addr = addr_q;
  assign wr_data = rx_next;
  assign sdo     = (ph_q == PH_DATA) & rd_q & tx_q[WORD_W-1];
  assign phase   = ph_q;
  assign bit_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !live) begin
      ph_q   <= PH_INSTR;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else if (sck_rise) begin
      if (instr_done) begin
        ph_q   <= PH_DATA;
        cnt_q  <= '0;
        rx_q   <= '0;
        rd_q   <= rx_next[INSTR_BITS-1];
        addr_q <= dec_addr;
        tx_q   <= rx_next[INSTR_BITS-1] ? msb_align(rd_word, dec_addr) : '0;
      end else if (data_last) begin
        ph_q  <= PH_INSTR;
        cnt_q <= '0;
        rx_q  <= '0;
        tx_q  <= '0;
        rd_q  <= 1'b0;
      end else begin
        rx_q  <= rx_next;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else if (sck_fall && ph_q == PH_DATA && cnt_q != '0) begin
      tx_q <= tx_q << 1;
    end
  end
endmodule

// File: rtl/spc_commit_sync.sv
module spc_commit_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic io_update,
  output logic commit
);
  logic upd_q, commit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_q    <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      upd_q    <= io_update;
      commit_q <= io_update & ~upd_q;
    end
  end

  assign commit = commit_q;
endmodule

// File: rtl/spc_regbank.sv
module spc_regbank
  import spc_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       commit,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [WORD_W-1:0]          rd_word,
  output logic [NUM_REGS*WORD_W-1:0] act_flat
);
  logic [WORD_W-1:0] hold_q [NUM_REGS];
  logic [WORD_W-1:0] act_q  [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q[i] <= '0;
        act_q[i]  <= '0;
      end else begin
        if (commit) act_q[i] <= hold_q[i];
        if (wr_en && int'(wr_addr) == i) hold_q[i] <= wr_data;
      end
    end
    assign act_flat[i*WORD_W +: WORD_W] = act_q[i];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(rd_addr) == i) rd_word = act_q[i];
  end
endmodule

// File: rtl/spc_top.sv
module spc_top
  import spc_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sck,
  input  logic                       csn,
  input  logic                       sdi,
  output logic                       sdo,
  input  logic                       io_abort,
  input  logic                       io_update,
  output logic [NUM_REGS*WORD_W-1:0] act_regs
);
  logic [ADDR_W-1:0] dec_addr_w, wr_addr_w;
  logic [WORD_W-1:0] rd_word_w, wr_data_w;
  logic              instr_done_w, wr_done_w, commit_w;
  phase_t            phase_w;
  logic [CNT_W-1:0]  bit_cnt_w;

  spc_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (sck),
    .csn        (csn),
    .sdi        (sdi),
    .abort      (io_abort),
    .rd_word    (rd_word_w),
    .dec_addr   (dec_addr_w),
    .instr_done (instr_done_w),
    .wr_done    (wr_done_w),
    .wr_addr    (wr_addr_w),
    .wr_data    (wr_data_w),
    .sdo        (sdo),
    .phase      (phase_w),
    .bit_cnt    (bit_cnt_w)
  );

  spc_commit_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_update (io_update),
    .commit    (commit_w)
  );

  spc_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_done_w),
    .wr_addr  (wr_addr_w),
    .wr_data  (wr_data_w),
    .commit   (commit_w),
    .rd_addr  (dec_addr_w),
    .rd_word  (rd_word_w),
    .act_flat (act_regs)
  );
endmodule

// File: rtl/spc_top_chk.sv
module spc_top_chk
  import spc_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       csn,
  input logic                       io_abort,
  input logic                       io_update,
  input logic                       sdo,
  input logic                       commit,
  input logic                       instr_done,
  input logic                       wr_done,
  input phase_t                     phase,
  input logic [CNT_W-1:0]           bit_cnt,
  input logic [NUM_REGS*WORD_W-1:0] act_regs
);
  p_commit_after_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_update) |=> commit);

  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_regs));

  p_deselect_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csn |=> !sdo);

  p_abort_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_abort |=> (phase == PH_INSTR && bit_cnt == '0 && !sdo));

  p_single_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_done, wr_done}));

  p_instr_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INSTR) |-> (bit_cnt < CNT_W'(INSTR_BITS)));
endmodule

bind spc_top spc_top_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csn        (csn),
  .io_abort   (io_abort),
  .io_update  (io_update),
  .sdo        (sdo),
  .commit     (commit_w),
  .instr_done (instr_done_w),
  .wr_done    (wr_done_w),
  .phase      (phase_w),
  .bit_cnt    (bit_cnt_w),
  .act_regs   (act_regs)
);

// File: tb/spc_top_tb_top.sv
module spc_top_tb_top;
  localparam int NREG = 12;

  logic clk = 1'b0;
  logic rst_n, sck, csn, sdi, io_abort, io_update;
  logic sdo;
  logic [NREG*32-1:0] act_regs;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] exp_buf [32];
  logic [31:0] exp_act [32];

  always #2 clk = ~clk;

  spc_top #(.NUM_REGS(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .sdi(sdi), .sdo(sdo),
    .io_abort(io_abort), .io_update(io_update), .act_regs(act_regs)
  );

  function automatic int blen(int a);
    return (a % 4) + 1;
  endfunction

  function automatic logic [31:0] lmask(int a);
    return (blen(a) == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * blen(a))) - 32'h1);
  endfunction

  function automatic logic [31:0] pat(int a, int k);
    return ((32'(a) * 32'h9E37_79B1) ^ (32'(k) * 32'h0101_0101) ^ 32'h5A5A_0F0F) & lmask(a);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all_act(input string tag);
    for (int a = 0; a < NREG; a++) chk(tag, act_regs[a*32 +: 32], exp_act[a]);
  endtask

  task automatic bit_io(input logic b, input logic upd_here, output logic o);
    @(negedge clk) sck = 1'b0; sdi = b;
    @(negedge clk) o = sdo; if (upd_here) io_update = 1'b1;
    @(negedge clk) sck = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic o;
    for (int i = 7; i >= 0; i--) bit_io(v[i], 1'b0, o);
  endtask

  task automatic data_io(input int a, input logic [31:0] wd, input logic upd_last,
                         output logic [31:0] rd);
    logic o;
    rd = '0;
    for (int i = 8 * blen(a) - 1; i >= 0; i--) begin
      bit_io(wd[i], upd_last && (i == 0), o);
      rd = {rd[30:0], o};
    end
  endtask

  task automatic cs_begin();
    @(negedge clk) csn = 1'b0;
  endtask

  task automatic cs_end();
    @(negedge clk) sck = 1'b0;
    @(negedge clk) csn = 1'b1; io_update = 1'b0;
    @(negedge clk);
  endtask

  task automatic op(input logic rd_flag, input int a, input logic [1:0] junk,
                    input logic [31:0] wd, output logic [31:0] rdv);
    send_byte({rd_flag, junk, 5'(a)});
    data_io(a, wd, 1'b0, rdv);
    if (!rd_flag && a < NREG) exp_buf[a] = wd;
  endtask

  // R5: strobe timing, old value after one edge, new after the second
  task automatic do_update(input string tag);
    @(negedge clk) io_update = 1'b1;
    @(negedge clk) chk_all_act(tag);
    io_update = 1'b0;
    for (int a = 0; a < 32; a++) exp_act[a] = exp_buf[a];
    @(negedge clk) chk_all_act(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rv, v_old;
    rst_n = 1'b0; sck = 1'b0; csn = 1'b1; sdi = 1'b0; io_abort = 1'b0; io_update = 1'b0;
    for (int a = 0; a < 32; a++) begin exp_buf[a] = '0; exp_act[a] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_all_act("R1 reset act");
    chk("R1 reset sdo", 32'(sdo), 32'h0);

    // R3 / R9: write every address, including unmapped ones
    for (int a = 0; a < 32; a++) begin
      cs_begin(); op(1'b0, a, 2'b00, pat(a, 1), rv); cs_end();
    end
    // R4: nothing active yet
    chk_all_act("R4 before update");
    for (int a = 0; a < 32; a++) begin
      cs_begin(); op(1'b1, a, 2'b00, '0, rv); cs_end();
      chk("R4 R6 read before update", rv, 32'h0);
    end

    do_update("R5 commit");

    // R6 R9 R2: read back everything, with junk bits 6:5
    for (int a = 0; a < 32; a++) begin
      cs_begin(); op(1'b1, a, 2'(a), '0, rv); cs_end();
      chk(a < NREG ? "R6 R2 read active" : "R9 unmapped read", rv,
          a < NREG ? exp_act[a] : 32'h0);
    end

    // R3: several operations in one select window
    cs_begin();
    op(1'b0, 9, 2'b00, pat(9, 2), rv);
    op(1'b1, 10, 2'b00, '0, rv);
    chk("R3 back-to-back read 10", rv, exp_act[10]);
    op(1'b1, 11, 2'b00, '0, rv);
    chk("R3 back-to-back read 11", rv, exp_act[11]);
    op(1'b1, 9, 2'b00, '0, rv);
    chk("R4 R3 read 9 still old", rv, exp_act[9]);
    cs_end();
    do_update("R3 R5 commit 9");

    // R7: abort part-way through a write to register 1
    cs_begin();
    send_byte({1'b0, 2'b00, 5'd1});
    for (int i = 0; i < 5; i++) begin logic o; bit_io(1'b1, 1'b0, o); end
    @(negedge clk) io_abort = 1'b1;
    @(negedge clk) io_abort = 1'b0;
    op(1'b0, 2, 2'b00, pat(2, 3), rv);
    cs_end();
    do_update("R7 abort write");

    // R8: deselect part-way through a write to register 5
    cs_begin();
    send_byte({1'b0, 2'b00, 5'd5});
    for (int i = 0; i < 3; i++) begin logic o; bit_io(1'b0, 1'b0, o); end
    cs_end();
    cs_begin(); op(1'b0, 6, 2'b00, pat(6, 4), rv); cs_end();
    do_update("R8 deselect write");

    // R7: abort a read, then read in the same window
    cs_begin();
    send_byte({1'b1, 2'b00, 5'd3});
    for (int i = 0; i < 4; i++) begin logic o; bit_io(1'b0, 1'b0, o); end
    @(negedge clk) io_abort = 1'b1;
    @(negedge clk) io_abort = 1'b0;
    @(negedge clk) chk("R7 sdo after abort", 32'(sdo), 32'h0);
    op(1'b1, 7, 2'b00, '0, rv);
    chk("R7 read after abort", rv, exp_act[7]);
    cs_end();

    // R10: write completion and commit on the same edge
    v_old = exp_act[3];
    for (int a = 0; a < 32; a++) exp_act[a] = exp_buf[a];
    cs_begin();
    send_byte({1'b0, 2'b00, 5'd3});
    data_io(3, pat(3, 5), 1'b1, rv);
    cs_end();
    exp_buf[3] = pat(3, 5);
    chk("R10 old value committed", act_regs[3*32 +: 32], v_old);
    do_update("R10 pending value");
    chk("R10 new value after strobe", act_regs[3*32 +: 32], pat(3, 5));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule